// File: doc/BRIEF.md
# Speculative Load Validity Table

This block tracks loads that a pipeline has moved ahead of possibly conflicting stores. When such a load issues, its destination register number, byte address, access width and a small load-kind code are recorded. Every store that later passes through the snoop port is compared by byte range against all recorded loads, and any load it touches is dropped. When the pipeline reaches the original program position of the load, it asks whether the register still holds a valid speculative value. A hit means the value stands. A miss tells the pipeline to recover, either by reloading the register or by branching to compiler-written fix-up code, depending on which kind of check was issued.

The table holds 32 entries arranged as 16 sets of 2 ways. The set is chosen by the low four bits of the register number, and the remaining bits form the tag. A fresh load to a register that already has an entry overwrites that entry in place. When a set is full, a per-set round-robin pointer picks the victim. The table can also be emptied in one cycle, and a check that hits can remove its entry as it reads it.

Top module: `spec_load_table`

## Requirements
- R1: After reset, and after any later reset, every check misses. While no check is answered, respValid, respHit, respReload and respRecover are all low.
- R2: An allocate makes the register's entry visible to checks from the next cycle on. A hitting check returns the stored size code on respSize and the stored kind on respKind.
- R3: A check raised in cycle N is answered in cycle N+1 with respValid high and exactly one of three flags set: respHit on a hit, respReload on a miss with checkBranch=0, or respRecover on a miss with checkBranch=1. On a miss, respSize and respKind are 0.
- R4: Size code s (0,1,2,3) covers 2^s bytes (1, 2, 4, 8) from the given address. A snooped store removes every entry whose byte range shares at least one byte with the store's range. Ranges that only touch edges leave the entry in place.
- R5: A snoop and a check in the same cycle: the snoop acts first, so a check of an entry that the store removes misses in that very response.
- R6: An allocate and a check in the same cycle: the check sees the table as it was before the allocate.
- R7: An allocate to a register that already has an entry replaces it. Afterwards only the new address range, size and kind apply.
- R8: Registers whose low four bits match share a 2-way set. An allocate into a full set with no matching register evicts a way chosen by a per-set pointer. The pointer starts at way 0, advances only on such evictions, and the evicted register then misses.
- R9: A hitting check with checkClear=1 removes the entry after answering. A check with checkClear=0 leaves the entry in place.
- R10: invalAll removes every entry. A check in the same cycle misses. An allocate in the same cycle is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocValid | input | 1 | Record a speculative load this cycle |
| allocReg | input | 7 | Destination register number of the load |
| allocAddr | input | 32 | First byte address of the load |
| allocSize | input | 2 | Size code, 2^code bytes |
| allocKind | input | 2 | Load-kind code stored with the entry |
| snoopValid | input | 1 | A store is presented for comparison |
| snoopAddr | input | 32 | First byte address of the store |
| snoopSize | input | 2 | Store size code, 2^code bytes |
| checkValid | input | 1 | Check request this cycle |
| checkReg | input | 7 | Register number being checked |
| checkBranch | input | 1 | 1: miss branches to fix-up code, 0: miss reloads |
| checkClear | input | 1 | Remove the entry if the check hits |
| invalAll | input | 1 | Empty the whole table |
| respValid | output | 1 | Check answer valid (one cycle after the request) |
| respHit | output | 1 | Entry present and intact |
| respReload | output | 1 | Miss on a reload-type check |
| respRecover | output | 1 | Miss on a branch-type check |
| respSize | output | 2 | Size code of the hit entry, else 0 |
| respKind | output | 2 | Kind code of the hit entry, else 0 |

## Verification
Three pairs of operations can meet in one cycle. A store snoop can meet a check, an allocate can meet a check, and a flush can meet both an allocate and a check. The vector table drives each pair together in a single row. The response of that row is compared against the ordering rules: a store acts before a check, an allocate becomes visible only one cycle later, and an allocate survives a flush in the same cycle. The row that follows then shows whether the table state was left as those rules require.

// File: rtl/spec_load_table_pkg.sv
package spec_load_table_pkg;

  localparam int REG_W   = 7;
  localparam int ADDR_W  = 32;
  localparam int SIZE_W  = 2;
  localparam int KIND_W  = 2;
  localparam int ENTRIES = 32;
  localparam int WAYS    = 2;
  localparam int SETS    = ENTRIES / WAYS;
  localparam int SET_W   = $clog2(SETS);
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W   = REG_W - SET_W;

  // Strobes from control to the entry store
  typedef struct packed {
    logic             wrEn;
    logic [SET_W-1:0] wrSet;
    logic [WAY_W-1:0] wrWay;
    logic             clrEn;
    logic [SET_W-1:0] clrSet;
    logic [WAY_W-1:0] clrWay;
    logic             flush;
  } sltStrobe_t;

  function automatic logic [ADDR_W:0] spanBytes(input logic [SIZE_W-1:0] code);
    return {{ADDR_W{1'b0}}, 1'b1} << code;
  endfunction

  // Half-open byte ranges [a, a+2^sa) and [b, b+2^sb) intersect
  function automatic logic rangesMeet(input logic [ADDR_W-1:0] a, input logic [SIZE_W-1:0] sa,
                                      input logic [ADDR_W-1:0] b, input logic [SIZE_W-1:0] sb);
    logic [ADDR_W:0] aLo, bLo, aHi, bHi;
    aLo = {1'b0, a};
    bLo = {1'b0, b};
    aHi = aLo + spanBytes(sa);
    bHi = bLo + spanBytes(sb);
    return (aLo < bHi) && (bLo < aHi);
  endfunction

endpackage

// File: rtl/slt_entries.sv
module slt_entries
  import spec_load_table_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  sltStrobe_t        strobe,
  input  logic [SET_W-1:0]  allocSet,
  input  logic [TAG_W-1:0]  allocTag,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic [SIZE_W-1:0] allocSize,
  input  logic [KIND_W-1:0] allocKind,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic [SIZE_W-1:0] snoopSize,
  input  logic [SET_W-1:0]  checkSet,
  input  logic [TAG_W-1:0]  checkTag,
  output logic [WAYS-1:0]   allocMatch,
  output logic [WAYS-1:0]   allocUsed,
  output logic [WAYS-1:0]   checkLive,
  output logic [SIZE_W-1:0] checkSize,
  output logic [KIND_W-1:0] checkKind
);

  logic              entValid [ENTRIES];
  logic [TAG_W-1:0]  entTag   [ENTRIES];
  logic [ADDR_W-1:0] entAddr  [ENTRIES];
  logic [SIZE_W-1:0] entSize  [ENTRIES];
  logic [KIND_W-1:0] entKind  [ENTRIES];
  logic [ENTRIES-1:0] killed;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam int ESET = e / WAYS;
    localparam int EWAY = e % WAYS;

    assign killed[e] = snoopValid && entValid[e] &&
                       rangesMeet(entAddr[e], entSize[e], snoopAddr, snoopSize);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entValid[e] <= 1'b0;
        entTag[e]   <= '0;
        entAddr[e]  <= '0;
        entSize[e]  <= '0;
        entKind[e]  <= '0;
      end else begin
        if (strobe.flush || killed[e]) entValid[e] <= 1'b0;
        if (strobe.clrEn && strobe.clrSet == SET_W'(ESET) && strobe.clrWay == WAY_W'(EWAY))
          entValid[e] <= 1'b0;
        if (strobe.wrEn && strobe.wrSet == SET_W'(ESET) && strobe.wrWay == WAY_W'(EWAY)) begin
          entValid[e] <= 1'b1;
          entTag[e]   <= allocTag;
          entAddr[e]  <= allocAddr;
          entSize[e]  <= allocSize;
          entKind[e]  <= allocKind;
        end
      end
    end
  end

  always_comb begin
    checkSize = '0;
    checkKind = '0;
    for (int w = 0; w < WAYS; w++) begin
      int ai, ci;
      ai = int'(allocSet) * WAYS + w;
      ci = int'(checkSet) * WAYS + w;
      allocUsed[w]  = entValid[ai];
      allocMatch[w] = entValid[ai] && (entTag[ai] == allocTag);
      checkLive[w]  = entValid[ci] && (entTag[ci] == checkTag) && !killed[ci];
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (checkLive[w]) begin
        checkSize = entSize[int'(checkSet) * WAYS + w];
        checkKind = entKind[int'(checkSet) * WAYS + w];
      end
    end
  end

endmodule

// File: rtl/slt_ctrl.sv
module slt_ctrl
  import spec_load_table_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [REG_W-1:0]  allocReg,
  input  logic              checkValid,
  input  logic [REG_W-1:0]  checkReg,
  input  logic              checkBranch,
  input  logic              checkClear,
  input  logic              invalAll,
  input  logic [WAYS-1:0]   allocMatch,
  input  logic [WAYS-1:0]   allocUsed,
  input  logic [WAYS-1:0]   checkLive,
  input  logic [SIZE_W-1:0] checkSize,
  input  logic [KIND_W-1:0] checkKind,
  output sltStrobe_t        strobe,
  output logic [SET_W-1:0]  allocSet,
  output logic [TAG_W-1:0]  allocTag,
  output logic [SET_W-1:0]  checkSet,
  output logic [TAG_W-1:0]  checkTag,
  output logic              respValid,
  output logic              respHit,
  output logic              respReload,
  output logic              respRecover,
  output logic [SIZE_W-1:0] respSize,
  output logic [KIND_W-1:0] respKind
);

  logic [WAY_W-1:0] rrPtr [SETS];
  logic [WAY_W-1:0] matchWay, freeWay, liveWay, pickWay;
  logic             evict, hit;

  assign allocSet = allocReg[SET_W-1:0];
  assign allocTag = allocReg[REG_W-1:SET_W];
  assign checkSet = checkReg[SET_W-1:0];
  assign checkTag = checkReg[REG_W-1:SET_W];

  always_comb begin
    matchWay = '0;
    freeWay  = '0;
    liveWay  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (allocMatch[w]) matchWay = WAY_W'(w);
      if (!allocUsed[w]) freeWay  = WAY_W'(w);
      if (checkLive[w])  liveWay  = WAY_W'(w);
    end
    evict = !(|allocMatch) && (&allocUsed);
    if (|allocMatch)     pickWay = matchWay;
    else if (!evict)     pickWay = freeWay;
    else                 pickWay = rrPtr[allocSet];
    hit = checkValid && (|checkLive) && !invalAll;

    strobe.wrEn   = allocValid;
    strobe.wrSet  = allocSet;
    strobe.wrWay  = pickWay;
    strobe.clrEn  = hit && checkClear;
    strobe.clrSet = checkSet;
    strobe.clrWay = liveWay;
    strobe.flush  = invalAll;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) rrPtr[s] <= '0;
    end else if (allocValid && evict) begin
      rrPtr[allocSet] <= (rrPtr[allocSet] == WAY_W'(WAYS - 1)) ? '0 : rrPtr[allocSet] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid   <= 1'b0;
      respHit     <= 1'b0;
      respReload  <= 1'b0;
      respRecover <= 1'b0;
      respSize    <= '0;
      respKind    <= '0;
    end else begin
      respValid   <= checkValid;
      respHit     <= hit;
      respReload  <= checkValid && !hit && !checkBranch;
      respRecover <= checkValid && !hit && checkBranch;
      respSize    <= hit ? checkSize : '0;
      respKind    <= hit ? checkKind : '0;
    end
  end

endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
  import spec_load_table_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [REG_W-1:0]  allocReg,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic [SIZE_W-1:0] allocSize,
  input  logic [KIND_W-1:0] allocKind,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic [SIZE_W-1:0] snoopSize,
  input  logic              checkValid,
  input  logic [REG_W-1:0]  checkReg,
  input  logic              checkBranch,
  input  logic              checkClear,
  input  logic              invalAll,
  output logic              respValid,
  output logic              respHit,
  output logic              respReload,
  output logic              respRecover,
  output logic [SIZE_W-1:0] respSize,
  output logic [KIND_W-1:0] respKind
);

  sltStrobe_t        strobe;
  logic [SET_W-1:0]  allocSet, checkSet;
  logic [TAG_W-1:0]  allocTag, checkTag;
  logic [WAYS-1:0]   allocMatch, allocUsed, checkLive;
  logic [SIZE_W-1:0] checkSize;
  logic [KIND_W-1:0] checkKind;

  slt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocReg(allocReg),
    .checkValid(checkValid), .checkReg(checkReg),
    .checkBranch(checkBranch), .checkClear(checkClear), .invalAll(invalAll),
    .allocMatch(allocMatch), .allocUsed(allocUsed), .checkLive(checkLive),
    .checkSize(checkSize), .checkKind(checkKind),
    .strobe(strobe), .allocSet(allocSet), .allocTag(allocTag),
    .checkSet(checkSet), .checkTag(checkTag),
    .respValid(respValid), .respHit(respHit), .respReload(respReload),
    .respRecover(respRecover), .respSize(respSize), .respKind(respKind)
  );

  slt_entries entries_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .allocSet(allocSet), .allocTag(allocTag), .allocAddr(allocAddr),
    .allocSize(allocSize), .allocKind(allocKind),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr), .snoopSize(snoopSize),
    .checkSet(checkSet), .checkTag(checkTag),
    .allocMatch(allocMatch), .allocUsed(allocUsed), .checkLive(checkLive),
    .checkSize(checkSize), .checkKind(checkKind)
  );

endmodule

// File: rtl/slt_checker.sv
module slt_checker
  import spec_load_table_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              checkValid,
  input logic              checkBranch,
  input logic              invalAll,
  input logic              respValid,
  input logic              respHit,
  input logic              respReload,
  input logic              respRecover,
  input logic [SIZE_W-1:0] respSize,
  input logic [KIND_W-1:0] respKind
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R3
  resp_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (respValid == $past(checkValid)));

  // R3
  one_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ($countones({respHit, respReload, respRecover}) == 1));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> !(respHit || respReload || respRecover));

  // R3
  reload_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    (checkValid && !checkBranch) |=> !respRecover);

  // R10
  flush_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (checkValid && invalAll) |=> (respValid && !respHit));

  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !respHit |-> (respSize == '0 && respKind == '0));

endmodule

bind spec_load_table slt_checker chk_i (
  .clk(clk), .rstN(rstN), .checkValid(checkValid), .checkBranch(checkBranch),
  .invalAll(invalAll), .respValid(respValid), .respHit(respHit),
  .respReload(respReload), .respRecover(respRecover),
  .respSize(respSize), .respKind(respKind)
);

// File: tb/spec_load_table_tb_top.sv
module spec_load_table_tb_top;
  import spec_load_table_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              allocValid = 1'b0;
  logic [REG_W-1:0]  allocReg = '0;
  logic [ADDR_W-1:0] allocAddr = '0;
  logic [SIZE_W-1:0] allocSize = '0;
  logic [KIND_W-1:0] allocKind = '0;
  logic              snoopValid = 1'b0;
  logic [ADDR_W-1:0] snoopAddr = '0;
  logic [SIZE_W-1:0] snoopSize = '0;
  logic              checkValid = 1'b0;
  logic [REG_W-1:0]  checkReg = '0;
  logic              checkBranch = 1'b0;
  logic              checkClear = 1'b0;
  logic              invalAll = 1'b0;
  logic              respValid, respHit, respReload, respRecover;
  logic [SIZE_W-1:0] respSize;
  logic [KIND_W-1:0] respKind;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spec_load_table dut_i (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocReg(allocReg), .allocAddr(allocAddr),
    .allocSize(allocSize), .allocKind(allocKind),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr), .snoopSize(snoopSize),
    .checkValid(checkValid), .checkReg(checkReg), .checkBranch(checkBranch),
    .checkClear(checkClear), .invalAll(invalAll),
    .respValid(respValid), .respHit(respHit), .respReload(respReload),
    .respRecover(respRecover), .respSize(respSize), .respKind(respKind)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        aV;
    logic [6:0]  aReg;
    logic [15:0] aAddr;
    logic [1:0]  aSize;
    logic        sV;
    logic [15:0] sAddr;
    logic [1:0]  sSize;
    logic        cV;
    logic [6:0]  cReg;
    logic        cBr;
    logic        cClr;
    logic        inv;
    logic        eHit;
    logic [1:0]  eSize;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd5,1'b0,1'b0, 1'b0, 1'b0,2'd0}, // R1 empty, reload
    '{4'd3, 1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd5,1'b1,1'b0, 1'b0, 1'b0,2'd0}, // R3 empty, recover
    '{4'd6, 1'b1,7'd5,16'h0100,2'd2, 1'b0,16'h0000,2'd0, 1'b1,7'd5,1'b0,1'b0, 1'b0, 1'b0,2'd0}, // R6 alloc+check
    '{4'd2, 1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd5,1'b0,1'b0, 1'b0, 1'b1,2'd2}, // R2 visible
    '{4'd4, 1'b0,7'd0,16'h0000,2'd0, 1'b1,16'h0104,2'd0, 1'b1,7'd5,1'b0,1'b0, 1'b0, 1'b1,2'd2}, // R4 upper edge
    '{4'd4, 1'b0,7'd0,16'h0000,2'd0, 1'b1,16'h00FC,2'd2, 1'b1,7'd5,1'b0,1'b0, 1'b0, 1'b1,2'd2}, // R4 lower edge
    '{4'd5, 1'b0,7'd0,16'h0000,2'd0, 1'b1,16'h00FE,2'd2, 1'b1,7'd5,1'b0,1'b0, 1'b0, 1'b0,2'd0}, // R5 snoop+check
    '{4'd4, 1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd5,1'b0,1'b0, 1'b0, 1'b0,2'd0}, // R4 gone
    '{4'd2, 1'b1,7'd6,16'h0200,2'd3, 1'b0,16'h0000,2'd0, 1'b0,7'd0,1'b0,1'b0, 1'b0, 1'b0,2'd0}, // R2 alloc r6
    '{4'd7, 1'b1,7'd6,16'h0300,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd6,1'b0,1'b0, 1'b0, 1'b1,2'd3}, // R7 replace
    '{4'd7, 1'b0,7'd0,16'h0000,2'd0, 1'b1,16'h0204,2'd1, 1'b1,7'd6,1'b0,1'b0, 1'b0, 1'b1,2'd0}, // R7 old range
    '{4'd4, 1'b0,7'd0,16'h0000,2'd0, 1'b1,16'h0300,2'd0, 1'b1,7'd6,1'b0,1'b0, 1'b0, 1'b0,2'd0}, // R4 one byte
    '{4'd8, 1'b1,7'd3,16'h0400,2'd0, 1'b0,16'h0000,2'd0, 1'b0,7'd0,1'b0,1'b0, 1'b0, 1'b0,2'd0}, // R8 fill way0
    '{4'd8, 1'b1,7'd19,16'h0410,2'd0,1'b0,16'h0000,2'd0, 1'b0,7'd0,1'b0,1'b0, 1'b0, 1'b0,2'd0}, // R8 fill way1
    '{4'd8, 1'b1,7'd35,16'h0420,2'd1,1'b0,16'h0000,2'd0, 1'b1,7'd3,1'b0,1'b0, 1'b0, 1'b1,2'd0}, // R8 evict way0
    '{4'd8, 1'b1,7'd51,16'h0430,2'd2,1'b0,16'h0000,2'd0, 1'b1,7'd3,1'b0,1'b0, 1'b0, 1'b0,2'd0}, // R8 r3 gone
    '{4'd8, 1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd19,1'b0,1'b0, 1'b0, 1'b0,2'd0}, // R8 r19 gone
    '{4'd8, 1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd35,1'b0,1'b0, 1'b0, 1'b1,2'd1}, // R8 r35 kept
    '{4'd8, 1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd51,1'b0,1'b0, 1'b0, 1'b1,2'd2}, // R8 r51 kept
    '{4'd9, 1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd35,1'b1,1'b1, 1'b0, 1'b1,2'd1}, // R9 clear hit
    '{4'd9, 1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd35,1'b0,1'b0, 1'b0, 1'b0,2'd0}, // R9 cleared
    '{4'd9, 1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd51,1'b0,1'b0, 1'b0, 1'b1,2'd2}, // R9 no clear
    '{4'd9, 1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd51,1'b0,1'b0, 1'b0, 1'b1,2'd2}, // R9 kept
    '{4'd10,1'b1,7'd8,16'h0500,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd51,1'b0,1'b0, 1'b1, 1'b0,2'd0}, // R10 flush+check
    '{4'd10,1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd8,1'b0,1'b0, 1'b0, 1'b1,2'd0}, // R10 alloc kept
    '{4'd10,1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd51,1'b0,1'b0, 1'b0, 1'b0,2'd0}  // R10 flushed
  };

  task automatic idleInputs();
    allocValid = 1'b0; snoopValid = 1'b0; checkValid = 1'b0;
    checkBranch = 1'b0; checkClear = 1'b0; invalAll = 1'b0;
  endtask

  task automatic judge(input int req, input logic eValid, input logic eHit, input logic eRel,
                       input logic eRec, input logic [1:0] eSize, input logic [1:0] eKind,
                       input logic useKind);
    logic [7:0] act, exp;
    act = {respValid, respHit, respReload, respRecover, respSize, useKind ? respKind : 2'd0};
    exp = {eValid, eHit, eRel, eRec, eSize, useKind ? eKind : 2'd0};
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d: {valid,hit,reload,recover,size,kind} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic doCheck(input int req, input logic [6:0] r, input logic br,
                         input logic eHit, input logic [1:0] eSize, input logic [1:0] eKind);
    @(negedge clk);
    idleInputs();
    checkValid = 1'b1; checkReg = r; checkBranch = br;
    @(posedge clk); #1;
    judge(req, 1'b1, eHit, !eHit && !br, !eHit && br, eHit ? eSize : 2'd0, eHit ? eKind : 2'd0, 1'b1);
  endtask

  task automatic doAlloc(input logic [6:0] r, input logic [15:0] a, input logic [1:0] s,
                         input logic [1:0] k);
    @(negedge clk);
    idleInputs();
    allocValid = 1'b1; allocReg = r; allocAddr = {16'h0, a}; allocSize = s; allocKind = k;
    @(posedge clk); #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    finishRun();
  end

  initial begin : main
    idleInputs();
    repeat (3) @(posedge clk);
    #1;
    // R1: quiet outputs while held in reset
    judge(1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    judge(1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      allocValid = VECS[i].aV;  allocReg = VECS[i].aReg;
      allocAddr = {16'h0, VECS[i].aAddr}; allocSize = VECS[i].aSize; allocKind = 2'd1;
      snoopValid = VECS[i].sV;  snoopAddr = {16'h0, VECS[i].sAddr}; snoopSize = VECS[i].sSize;
      checkValid = VECS[i].cV;  checkReg = VECS[i].cReg;
      checkBranch = VECS[i].cBr; checkClear = VECS[i].cClr; invalAll = VECS[i].inv;
      @(posedge clk); #1;
      judge(int'(VECS[i].req), VECS[i].cV, VECS[i].cV && VECS[i].eHit,
            VECS[i].cV && !VECS[i].eHit && !VECS[i].cBr,
            VECS[i].cV && !VECS[i].eHit && VECS[i].cBr,
            (VECS[i].cV && VECS[i].eHit) ? VECS[i].eSize : 2'd0,
            (VECS[i].cV && VECS[i].eHit) ? 2'd1 : 2'd0, 1'b1);
    end

    // R2: kind code returned on hit
    doAlloc(7'd9, 16'h0600, 2'd1, 2'd2);
    doCheck(2, 7'd9, 1'b0, 1'b1, 2'd1, 2'd2);
    // R7: replacement brings new size and kind
    doAlloc(7'd9, 16'h0700, 2'd3, 2'd3);
    doCheck(7, 7'd9, 1'b1, 1'b1, 2'd3, 2'd3);
    // R4: 8-byte entry hit by a 1-byte store at its last byte
    @(negedge clk);
    idleInputs();
    snoopValid = 1'b1; snoopAddr = 32'h0000_0707; snoopSize = 2'd0;
    @(posedge clk); #1;
    doCheck(4, 7'd9, 1'b1, 1'b0, 2'd0, 2'd0);
    // R1: a later reset empties the table
    doAlloc(7'd10, 16'h0800, 2'd0, 2'd1);
    @(negedge clk);
    idleInputs();
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    doCheck(1, 7'd10, 1'b0, 1'b0, 2'd0, 2'd0);
    // R3: no check raised gives no answer
    @(negedge clk);
    idleInputs();
    @(posedge clk); #1;
    judge(3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1);

    @(negedge clk);
    finishRun();
  end

endmodule